// File: doc/BRIEF.md
# Multicycle Shared-Resource CPU Datapath

This block is the 32-bit register-transfer datapath of a small load/store processor that runs each instruction as a sequence of short steps. Every step uses at most one major resource: the single memory port, the register file or the single ALU. One memory port serves both instruction fetch and data access. One ALU computes the PC increment, the branch target, effective addresses and all arithmetic. Holding registers (instruction, memory data, two operand latches and an ALU result latch) carry values from one step to the next.

The block contains no sequencing logic. An external controller drives every multiplexer select and write enable on each cycle. It reads back the opcode and function fields of the held instruction and the ALU zero flag. The memory is external with a combinational read: `mem_rdata_i` must reflect `mem_addr_o` within the same cycle, and a write happens at the clock edge when `mem_we_o` is high.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_ni` is low, the PC, the instruction register, every holding register and every register-file entry are cleared. After reset `pc_o` and `mem_addr_o` read 0.
- R2: `mem_addr_o` is the PC when `addr_sel_i`=0 and the ALU result latch when `addr_sel_i`=1. `mem_re_o` and `mem_we_o` follow `mem_rd_i` and `mem_wr_i`.
- R3: The PC loads at a clock edge only when `pc_wr_i`=1, or when `pc_wr_cond_i`=1 and `zero_o`=1. Otherwise it holds.
- R4: `pc_src_i` selects the next PC: 00 = live ALU result, 01 = ALU result latch, 10 = {PC[31:28], IR[25:0], 00}, 11 = live ALU result.
- R5: The instruction register loads `mem_rdata_i` only when `ir_wr_i`=1. `opcode_o` = IR[31:26] and `funct_o` = IR[5:0] stay stable in every other cycle.
- R6: The ALU first operand is the PC when `src_a_sel_i`=0 and latch A when it is 1. The second operand is selected by `src_b_sel_i`: 00 = latch B, 01 = constant 4, 10 = extended immediate, 11 = extended immediate shifted left by 2. `alu_op_i` selects the operation: 0 add, 1 subtract, 2 and, 3 or, 4 signed set-less-than; 5 to 7 add. `zero_o` is high when the live ALU result is 0.
- R7: On every edge, latch A captures register IR[25:20..21] (rs = IR[25:21]) and latch B captures register rt = IR[20:16]. The ALU result latch captures the ALU result, so a decode step with PC and the shifted immediate yields the branch target PC+4+(sext(IR[15:0])<<2).
- R8: The immediate IR[15:0] is sign-extended when `ext_sign_i`=1 and zero-extended when it is 0.
- R9: A register write (`reg_wr_i`=1) goes to rd = IR[15:11] when `rd_sel_i`=1, or to rt = IR[20:16] when it is 0. The data is the ALU result latch when `wb_sel_i`=0 and the memory data register when it is 1.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: `mem_wdata_o` is latch B, so a store step writes register rt to the address held in the ALU result latch.
- R12: The memory data register captures `mem_rdata_i` on every edge, so a load step's data can be written back to rt in the following step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_wr_i | input | 1 | Unconditional PC write |
| pc_wr_cond_i | input | 1 | PC write qualified by the zero flag |
| pc_src_i | input | 2 | Next-PC source select |
| addr_sel_i | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| mem_rd_i | input | 1 | Memory read request |
| mem_wr_i | input | 1 | Memory write request |
| ir_wr_i | input | 1 | Instruction register load enable |
| reg_wr_i | input | 1 | Register file write enable |
| rd_sel_i | input | 1 | Write address select: 1 rd, 0 rt |
| wb_sel_i | input | 1 | Write data select: 0 ALU latch, 1 memory data register |
| src_a_sel_i | input | 1 | ALU operand A select |
| src_b_sel_i | input | 2 | ALU operand B select |
| alu_op_i | input | 3 | ALU operation |
| ext_sign_i | input | 1 | Immediate extension: 1 sign, 0 zero |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data |
| opcode_o | output | 6 | Held instruction opcode field |
| funct_o | output | 6 | Held instruction function field |
| zero_o | output | 1 | Live ALU result equals zero |
| pc_o | output | 32 | Program counter |

## Verification
The bench plays the controller for a program of OR-immediate, register, load, store, branch and jump instructions. A behavioural machine model follows the PC and the register contents, and every stored word exposes the register state. The program writes to register 0, uses negative load offsets that would break a zero-extending address path, and sets an immediate with bit 15 set for OR, where a sign-extending design would corrupt the upper half. It runs a branch both taken and not taken, and a subtract that sets the zero flag with no PC write attached, where a PC that ignores its write qualification would jump. It also checks the opcode after a data read, which fails if the instruction register reloads on every cycle. A register write that confuses rd and rt shows up when the untouched register is stored.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG    = 2'd0,
    SRCB_FOUR   = 2'd1,
    SRCB_IMM    = 2'd2,
    SRCB_IMM_SH = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_ALU   = 2'd0,
    PCS_LATCH = 2'd1,
    PCS_JUMP  = 2'd2
  } pcsrc_e;

  localparam int unsigned IMM_W  = 16;
  localparam int unsigned FLD_W  = 6;
  localparam int unsigned JIDX_W = 26;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    case (alu_op_e'(op_i))
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, lt};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_imm_ext.sv
module mc_imm_ext
  import mc_dp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sign_i,
  output logic [W-1:0]     ext_o,
  output logic [W-1:0]     ext_sh_o
);
  localparam int unsigned PAD = W - IMM_W;

  assign ext_o    = {{PAD{sign_i & imm_i[IMM_W-1]}}, imm_i};
  assign ext_sh_o = {ext_o[W-3:0], 2'b00};
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 32,
  parameter int unsigned ADR_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADR_W-1:0] ra1_i,
  input  logic [ADR_W-1:0] ra2_i,
  output logic [W-1:0]     rd1_o,
  output logic [W-1:0]     rd2_o,
  input  logic             we_i,
  input  logic [ADR_W-1:0] wa_i,
  input  logic [W-1:0]     wd_i
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else begin
      // entry 0 is never written
      for (int i = 1; i < N; i++)
        if (we_i && (wa_i == ADR_W'(i))) regs_q[i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int unsigned   DATA_W   = 32,
  parameter int unsigned   NREGS    = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_wr_i,
  input  logic              pc_wr_cond_i,
  input  logic [1:0]        pc_src_i,
  input  logic              addr_sel_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  input  logic              ir_wr_i,
  input  logic              reg_wr_i,
  input  logic              rd_sel_i,
  input  logic              wb_sel_i,
  input  logic              src_a_sel_i,
  input  logic [1:0]        src_b_sel_i,
  input  logic [2:0]        alu_op_i,
  input  logic              ext_sign_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [FLD_W-1:0]  opcode_o,
  output logic [FLD_W-1:0]  funct_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam int unsigned RA_W = $clog2(NREGS);

  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [DATA_W-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_res, pc_next;
  logic [DATA_W-1:0] imm_ext, imm_sh;
  logic [RA_W-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
  logic              alu_zero, pc_en;

  assign rs_idx = RA_W'(ir_q[25:21]);
  assign rt_idx = RA_W'(ir_q[20:16]);
  assign rd_idx = RA_W'(ir_q[15:11]);
  assign wr_idx = rd_sel_i ? rd_idx : rt_idx;

  mc_regfile #(.W(DATA_W), .N(NREGS)) i_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (rs_idx),
    .ra2_i (rt_idx),
    .rd1_o (rf_rd1),
    .rd2_o (rf_rd2),
    .we_i  (reg_wr_i),
    .wa_i  (wr_idx),
    .wd_i  (wb_sel_i ? mdr_q : alu_out_q)
  );

  mc_imm_ext #(.W(DATA_W)) i_ext (
    .imm_i   (ir_q[IMM_W-1:0]),
    .sign_i  (ext_sign_i),
    .ext_o   (imm_ext),
    .ext_sh_o(imm_sh)
  );

  assign alu_a = src_a_sel_i ? a_q : pc_q;

  always_comb begin
    case (srcb_e'(src_b_sel_i))
      SRCB_REG:  alu_b = b_q;
      SRCB_FOUR: alu_b = DATA_W'(4);
      SRCB_IMM:  alu_b = imm_ext;
      default:   alu_b = imm_sh;
    endcase
  end

  mc_alu #(.W(DATA_W)) i_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .op_i  (alu_op_i),
    .res_o (alu_res),
    .zero_o(alu_zero)
  );

  always_comb begin
    case (pcsrc_e'(pc_src_i))
      PCS_LATCH: pc_next = alu_out_q;
      PCS_JUMP:  pc_next = {pc_q[DATA_W-1:DATA_W-4], ir_q[JIDX_W-1:0], 2'b00};
      default:   pc_next = alu_res;
    endcase
  end

  assign pc_en = pc_wr_i | (pc_wr_cond_i & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RESET_PC;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_next;
      if (ir_wr_i) ir_q <= mem_rdata_i;
      mdr_q     <= mem_rdata_i;
      a_q       <= rf_rd1;
      b_q       <= rf_rd2;
      alu_out_q <= alu_res;
    end
  end

  assign mem_addr_o  = addr_sel_i ? alu_out_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_re_o    = mem_rd_i;
  assign mem_we_o    = mem_wr_i;
  assign opcode_o    = ir_q[DATA_W-1:DATA_W-FLD_W];
  assign funct_o     = ir_q[FLD_W-1:0];
  assign zero_o      = alu_zero;
  assign pc_o        = pc_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pc_wr_i,
  input logic              pc_wr_cond_i,
  input logic [1:0]        pc_src_i,
  input logic              addr_sel_i,
  input logic              ir_wr_i,
  input logic              src_a_sel_i,
  input logic [1:0]        src_b_sel_i,
  input logic [2:0]        alu_op_i,
  input logic              zero_o,
  input logic [DATA_W-1:0] pc_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [5:0]        opcode_o,
  input logic [5:0]        funct_o,
  input logic [DATA_W-1:0] ir_q
);
  a_r3_pc_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_wr_i || (pc_wr_cond_i && zero_o)) |=> $stable(pc_o));

  a_r6_fetch_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && pc_src_i == 2'd0 && !src_a_sel_i && src_b_sel_i == 2'd1 && alu_op_i == 3'd0)
    |=> pc_o == $past(pc_o) + DATA_W'(4));

  a_r4_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && pc_src_i == 2'd2)
    |=> pc_o == {$past(pc_o[DATA_W-1:DATA_W-4]), $past(ir_q[25:0]), 2'b00});

  a_r5_ir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_wr_i |=> ($stable(opcode_o) && $stable(funct_o)));

  a_r2_fetch_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_sel_i |-> mem_addr_o == pc_o);
endmodule

bind mc_datapath mc_datapath_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_wr_i     (pc_wr_i),
  .pc_wr_cond_i(pc_wr_cond_i),
  .pc_src_i    (pc_src_i),
  .addr_sel_i  (addr_sel_i),
  .ir_wr_i     (ir_wr_i),
  .src_a_sel_i (src_a_sel_i),
  .src_b_sel_i (src_b_sel_i),
  .alu_op_i    (alu_op_i),
  .zero_o      (zero_o),
  .pc_o        (pc_o),
  .mem_addr_o  (mem_addr_o),
  .opcode_o    (opcode_o),
  .funct_o     (funct_o),
  .ir_q        (ir_q)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, reg_wr;
  logic        rd_sel, wb_sel, src_a, ext_sign;
  logic [1:0]  pc_src, src_b;
  logic [2:0]  alu_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_o;
  logic        mem_re, mem_we, zero_o;
  logic [5:0]  opcode, funct;

  logic [31:0] mem_m [256];
  logic [31:0] rf_m [32];
  logic [31:0] pc_m, ir_m, tgt_m;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [5:0] OP_R = 6'h00, OP_ORI = 6'h0d, OP_LW = 6'h23,
                         OP_SW = 6'h2b, OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24,
                         F_OR = 6'h25, F_SLT = 6'h2a;

  always #5 clk_i = ~clk_i;

  assign mem_rdata = mem_m[mem_addr[9:2]];

  mc_datapath i_mc_datapath (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_wr_i(pc_wr), .pc_wr_cond_i(pc_wr_cond),
    .pc_src_i(pc_src), .addr_sel_i(addr_sel), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .ir_wr_i(ir_wr), .reg_wr_i(reg_wr), .rd_sel_i(rd_sel), .wb_sel_i(wb_sel),
    .src_a_sel_i(src_a), .src_b_sel_i(src_b), .alu_op_i(alu_op), .ext_sign_i(ext_sign),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .opcode_o(opcode), .funct_o(funct), .zero_o(zero_o),
    .pc_o(pc_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [2:0] fmap(input logic [5:0] f);
    case (f)
      F_SUB:   return 3'd1;
      F_AND:   return 3'd2;
      F_OR:    return 3'd3;
      F_SLT:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] fref(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      F_SUB:   return a - b;
      F_AND:   return a & b;
      F_OR:    return a | b;
      F_SLT:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; pc_src = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0;
    ir_wr = 0; reg_wr = 0; rd_sel = 0; wb_sel = 0; src_a = 0; src_b = 0;
    alu_op = 0; ext_sign = 0;
  endtask

  // one clock; the environment memory takes a write at the edge
  task automatic tick();
    logic        we;
    logic [7:0]  idx;
    logic [31:0] wd;
    we = mem_we; idx = mem_addr[9:2]; wd = mem_wdata;
    @(posedge clk_i);
    @(negedge clk_i);
    if (we) mem_m[idx] = wd;
  endtask

  task automatic fetch(input logic [31:0] w);
    mem_m[pc_m[9:2]] = w;
    ir_m = w;
    idle(); mem_rd = 1; ir_wr = 1; src_b = 2'd1; pc_wr = 1;
    #1 chk("R2", mem_addr, pc_m);
    tick();
    pc_m = pc_m + 4;
    chk("R6", pc_o, pc_m);
    chk("R5", {26'd0, opcode}, {26'd0, w[31:26]});
    chk("R5", {26'd0, funct}, {26'd0, w[5:0]});
  endtask

  task automatic decode();
    idle(); src_b = 2'd3; ext_sign = 1;
    tick();
    tgt_m = pc_m + (sx(ir_m[15:0]) << 2);
    chk("R3", pc_o, pc_m);
  endtask

  task automatic do_r(input logic [5:0] f, input int rd, input int rs, input int rt);
    logic [31:0] res;
    fetch({OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, f});
    decode();
    idle(); src_a = 1; src_b = 2'd0; alu_op = fmap(f);
    res = fref(f, rf_m[rs], rf_m[rt]);
    #1 chk("R6", {31'd0, zero_o}, {31'd0, res == 0});
    tick();
    chk("R3", pc_o, pc_m);
    idle(); reg_wr = 1; rd_sel = 1;
    tick();
    if (rd != 0) rf_m[rd] = res;
  endtask

  task automatic do_ori(input int rt, input int rs, input logic [15:0] imm);
    logic [31:0] res;
    fetch({OP_ORI, 5'(rs), 5'(rt), imm});
    decode();
    idle(); src_a = 1; src_b = 2'd2; alu_op = 3'd3;
    res = rf_m[rs] | {16'd0, imm};
    tick();
    idle(); reg_wr = 1;
    tick();
    if (rt != 0) rf_m[rt] = res;
  endtask

  task automatic do_lw(input string tag, input int rt, input int rs, input logic [15:0] imm);
    logic [31:0] ea, ld;
    fetch({OP_LW, 5'(rs), 5'(rt), imm});
    decode();
    idle(); src_a = 1; src_b = 2'd2; ext_sign = 1;
    tick();
    ea = rf_m[rs] + sx(imm);
    idle(); addr_sel = 1; mem_rd = 1;
    #1 chk(tag, mem_addr, ea);
    chk("R2", {31'd0, mem_re}, 32'd1);
    ld = mem_m[ea[9:2]];
    tick();
    chk("R5", {26'd0, opcode}, {26'd0, OP_LW});
    idle(); reg_wr = 1; wb_sel = 1;
    tick();
    if (rt != 0) rf_m[rt] = ld;
  endtask

  task automatic do_sw(input string tag, input int rt, input int rs, input logic [15:0] imm);
    logic [31:0] ea;
    fetch({OP_SW, 5'(rs), 5'(rt), imm});
    decode();
    idle(); src_a = 1; src_b = 2'd2; ext_sign = 1;
    tick();
    ea = rf_m[rs] + sx(imm);
    idle(); addr_sel = 1; mem_wr = 1;
    #1 chk("R11", mem_addr, ea);
    chk("R11", {31'd0, mem_we}, 32'd1);
    chk(tag, mem_wdata, rf_m[rt]);
    tick();
  endtask

  task automatic do_beq(input int rs, input int rt, input logic [15:0] imm);
    logic eq;
    fetch({OP_BEQ, 5'(rs), 5'(rt), imm});
    decode();
    eq = (rf_m[rs] == rf_m[rt]);
    idle(); src_a = 1; src_b = 2'd0; alu_op = 3'd1; pc_wr_cond = 1; pc_src = 2'd1;
    #1 chk("R6", {31'd0, zero_o}, {31'd0, eq});
    tick();
    if (eq) pc_m = tgt_m;
    chk(eq ? "R7" : "R3", pc_o, pc_m);
  endtask

  task automatic do_j(input logic [25:0] idx);
    fetch({OP_J, idx});
    decode();
    idle(); pc_wr = 1; pc_src = 2'd2;
    tick();
    pc_m = {pc_m[31:28], idx, 2'b00};
    chk("R4", pc_o, pc_m);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 32'h0;
    for (int i = 0; i < 32; i++) rf_m[i] = 32'h0;
    mem_m[135] = 32'hCAFE_F00D;   // byte address 0x21C
    pc_m = 0; ir_m = 0;
    idle();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1", pc_o, 32'h0);
    chk("R1", mem_addr, 32'h0);
    chk("R1", {26'd0, opcode}, 32'h0);
    @(negedge clk_i);

    do_ori(1, 0, 16'h8001);          // R8: zero extension keeps upper half clear
    do_ori(2, 0, 16'h0005);
    do_r(F_ADD, 3, 1, 2);
    do_r(F_SUB, 4, 2, 1);
    do_r(F_AND, 5, 1, 2);
    do_r(F_OR,  6, 1, 2);
    do_r(F_SLT, 7, 4, 1);
    do_r(F_SLT, 8, 1, 4);
    do_r(F_SUB, 9, 2, 2);            // zero set, no PC write
    do_sw("R8", 1, 0, 16'h0200);
    do_sw("R6", 3, 0, 16'h0204);
    do_sw("R6", 4, 0, 16'h0208);
    do_sw("R6", 5, 0, 16'h020C);
    do_sw("R6", 6, 0, 16'h0210);
    do_sw("R6", 7, 0, 16'h0214);
    do_sw("R6", 8, 0, 16'h0218);
    do_sw("R9", 9, 0, 16'h0240);
    do_ori(0, 1, 16'hFFFF);          // write to register 0
    do_sw("R10", 0, 0, 16'h0220);
    do_r(F_ADD, 0, 1, 1);
    do_sw("R10", 0, 0, 16'h0224);
    do_r(F_ADD, 12, 1, 2);           // rt = r2 must stay 5
    do_sw("R9", 2, 0, 16'h0228);
    do_sw("R9", 12, 0, 16'h022C);
    do_ori(10, 0, 16'h0220);
    do_lw("R8", 11, 10, 16'hFFFC);   // negative offset -> 0x21C
    do_sw("R12", 11, 0, 16'h0230);
    do_lw("R12", 13, 0, 16'h0204);   // reads back earlier store of r3
    do_sw("R12", 13, 10, 16'h0014);
    do_beq(1, 1, 16'h0002);          // taken, skips two words
    do_beq(1, 2, 16'h0003);          // not taken
    do_j(26'h40);
    do_r(F_ADD, 14, 11, 11);
    do_sw("R11", 14, 0, 16'h0238);
    do_beq(0, 0, 16'hFFFE);          // taken backwards by one instruction
    done = 1;
    summary();
    $finish;
  end
endmodule